// File: doc/BRIEF.md
# Timer Output Compare Unit

This unit watches one of two free-running 16-bit timers and reacts when the selected timer reaches a programmed 16-bit compare value. On the first cycle of a match it sets a sticky interrupt flag. Depending on a 4-bit mode code, it also sets, clears or toggles a dedicated compare output latch, or leaves that latch alone. One of these modes is a pure software-interrupt mode that only raises the flag. The latch is separate from any general-purpose port data latch. It reaches the pin only while the direction input selects output.

Software programs the unit through three strobes. One loads the compare value. One loads a control word that holds the mode, the timer select and the interrupt enable. One clears the flag. Writing an all-zero control word turns the unit off and forces the compare latch to its default low level. The timers are inputs. The unit produces no trigger for other blocks.

Top module: `ocmp_unit`

## Requirements
- R1: After reset the compare value, mode, timer select, interrupt enable, flag and latch are all zero, `pin_oe` is 0, `pin_out` is 0 and `irq` is 0.
- R2: The compare value is checked every cycle against the full 16 bits of `timer_a` when control bit 4 is 0, or of `timer_b` when it is 1. The timer that is not selected has no effect.
- R3: When the mode field (control bits 3:0) is 4'b1000, a match sets the latch to 1 at the clock edge on which the match is sampled.
- R4: With mode 4'b1001, a match clears the latch to 0 at that same edge.
- R5: With mode 4'b0010, a match inverts the latch at that same edge.
- R6: With mode 4'b1010 (software interrupt), a match sets the flag and leaves the latch unchanged.
- R7: Any other nonzero mode sets the flag on a match and leaves the latch unchanged. Mode 4'b0000 neither sets the flag nor changes the latch.
- R8: Only the first cycle of equality counts as a match. A timer that stays at the compare value does not trigger again until equality has first dropped.
- R9: The flag stays set until a `flag_clr` strobe clears it. If a match and `flag_clr` fall in the same cycle, the flag is set.
- R10: `irq` is the flag ANDed with the interrupt enable (control bit 5).
- R11: A control write of all zeros forces the latch to 0 at that edge. This overrides any match in the same cycle.
- R12: `pin_oe` is the inverse of `dir_in`, registered one cycle. `pin_out` shows the latch while `pin_oe` is 1 and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_wr | input | 1 | Load strobe for the compare value |
| cmp_wdata | input | 16 | New compare value |
| ctl_wr | input | 1 | Load strobe for the control word |
| ctl_wdata | input | 6 | Control word: [3:0] mode, [4] timer select, [5] interrupt enable |
| flag_clr | input | 1 | Clears the interrupt flag |
| dir_in | input | 1 | Pin direction, 0 selects output |
| timer_a | input | 16 | First timer value |
| timer_b | input | 16 | Second timer value |
| pin_out | output | 1 | Compare latch, gated by the output enable |
| pin_oe | output | 1 | Pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
A corrupted latch shows on `pin_out` at the negedge that follows the offending clock edge, provided the pin is enabled. A wrong flag shows on `irq` in that same half cycle, provided the interrupt is enabled. A bad equality history is harder to see. It shows up only at the next match, either as a missed action or as a second toggle while the timer holds its value. For this reason the stimulus holds timers at the compare value for several cycles and keeps toggle mode active.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int MODE_W = 4;
  localparam logic [MODE_W-1:0] MODE_OFF = 4'b0000;
  localparam logic [MODE_W-1:0] MODE_SET = 4'b1000;
  localparam logic [MODE_W-1:0] MODE_CLR = 4'b1001;
  localparam logic [MODE_W-1:0] MODE_TGL = 4'b0010;
  localparam logic [MODE_W-1:0] MODE_SWI = 4'b1010;

  typedef struct packed {
    logic              irq_en;
    logic              tsel;
    logic [MODE_W-1:0] mode;
  } ctl_t;

  // latch value after a match under the given mode
  function automatic logic match_next(input logic [MODE_W-1:0] mode, input logic cur);
    case (mode)
      MODE_SET: match_next = 1'b1;
      MODE_CLR: match_next = 1'b0;
      MODE_TGL: match_next = ~cur;
      default:  match_next = cur;
    endcase
  endfunction

  // does a match under this mode raise the flag
  function automatic logic match_flags(input logic [MODE_W-1:0] mode);
    match_flags = (mode != MODE_OFF);
  endfunction
endpackage

// File: rtl/ocmp_regs.sv
module ocmp_regs
  import ocmp_pkg::*;
#(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_wr,
  input  logic [TW-1:0] cmp_wdata,
  input  logic          ctl_wr,
  input  ctl_t          ctl_wdata,
  output logic [TW-1:0] cmp_q,
  output ctl_t          ctl_q,
  output logic          ctl_zero_wr
);
  assign ctl_zero_wr = ctl_wr && (ctl_wdata == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '0;
      ctl_q <= '0;
    end else begin
      if (cmp_wr) cmp_q <= cmp_wdata;
      if (ctl_wr) ctl_q <= ctl_wdata;
    end
  end
endmodule

// File: rtl/ocmp_match.sv
module ocmp_match #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] timer_a,
  input  logic [TW-1:0] timer_b,
  input  logic          tsel,
  input  logic [TW-1:0] cmp_q,
  output logic          eq_now,
  output logic          hit
);
  logic [TW-1:0] tsrc;
  logic          eq_q;

  assign tsrc   = tsel ? timer_b : timer_a;
  assign eq_now = (tsrc == cmp_q);
  assign hit    = eq_now && !eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq_now;
  end
endmodule

// File: rtl/ocmp_action.sv
module ocmp_action
  import ocmp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hit,
  input  logic [MODE_W-1:0] mode,
  input  logic              ctl_zero_wr,
  input  logic              flag_clr,
  input  logic              dir_in,
  output logic              latch_q,
  output logic              flag_q,
  output logic              oe_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_q <= 1'b0;
      flag_q  <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      oe_q <= !dir_in;
      if (ctl_zero_wr)  latch_q <= 1'b0;
      else if (hit)     latch_q <= match_next(mode, latch_q);
      if (hit && match_flags(mode)) flag_q <= 1'b1;
      else if (flag_clr)            flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ocmp_unit.sv
module ocmp_unit
  import ocmp_pkg::*;
#(
  parameter int TW = 16,
  localparam int CW = MODE_W + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_wr,
  input  logic [TW-1:0] cmp_wdata,
  input  logic          ctl_wr,
  input  logic [CW-1:0] ctl_wdata,
  input  logic          flag_clr,
  input  logic          dir_in,
  input  logic [TW-1:0] timer_a,
  input  logic [TW-1:0] timer_b,
  output logic          pin_out,
  output logic          pin_oe,
  output logic          irq
);
  logic [TW-1:0] cmp_q;
  ctl_t          ctl_q;
  logic          ctl_zero_wr;
  logic          eq_now;
  logic          hit;
  logic          latch_q;
  logic          flag_q;
  logic          oe_q;

  ocmp_regs #(.TW(TW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_t'(ctl_wdata)), .cmp_q(cmp_q),
    .ctl_q(ctl_q), .ctl_zero_wr(ctl_zero_wr)
  );

  ocmp_match #(.TW(TW)) u_match (
    .clk(clk), .rst_n(rst_n), .timer_a(timer_a), .timer_b(timer_b),
    .tsel(ctl_q.tsel), .cmp_q(cmp_q), .eq_now(eq_now), .hit(hit)
  );

  ocmp_action u_action (
    .clk(clk), .rst_n(rst_n), .hit(hit), .mode(ctl_q.mode),
    .ctl_zero_wr(ctl_zero_wr), .flag_clr(flag_clr), .dir_in(dir_in),
    .latch_q(latch_q), .flag_q(flag_q), .oe_q(oe_q)
  );

  assign pin_oe  = oe_q;
  assign pin_out = oe_q & latch_q;
  assign irq     = flag_q & ctl_q.irq_en;
endmodule

// File: rtl/ocmp_unit_chk.sv
module ocmp_unit_chk
  import ocmp_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              hit,
  input logic [MODE_W-1:0] mode,
  input logic              ctl_zero_wr,
  input logic              flag_clr,
  input logic              latch_q,
  input logic              flag_q,
  input logic              pin_out,
  input logic              pin_oe,
  input logic              irq
);
  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == MODE_SET && !ctl_zero_wr) |=> latch_q);
  p_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == MODE_CLR) |=> !latch_q);
  p_toggle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == MODE_TGL && !ctl_zero_wr) |=> (latch_q != $past(latch_q)));
  p_swint_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == MODE_SWI && !ctl_zero_wr) |=> ($stable(latch_q) && flag_q));
  p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !ctl_zero_wr) |=> $stable(latch_q));
  p_no_retrigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !flag_clr) |=> flag_q);
  p_irq_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);
  p_zero_ctl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_zero_wr |=> !latch_q);
  p_pin_gate_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> !pin_out);
endmodule

bind ocmp_unit ocmp_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .hit(hit), .mode(ctl_q.mode),
  .ctl_zero_wr(ctl_zero_wr), .flag_clr(flag_clr), .latch_q(latch_q),
  .flag_q(flag_q), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
);

// File: tb/ocmp_unit_tb.sv
module ocmp_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmp_wr = 1'b0;
  logic [15:0] cmp_wdata = '0;
  logic        ctl_wr = 1'b0;
  logic [5:0]  ctl_wdata = '0;
  logic        flag_clr = 1'b0;
  logic        dir_in = 1'b1;
  logic [15:0] timer_a = '0;
  logic [15:0] timer_b = '0;
  logic        pin_out, pin_oe, irq;

  int n_run = 0;
  int n_fail = 0;

  // reference state
  logic [15:0] m_cmp = '0;
  logic [3:0]  m_mode = '0;
  logic        m_tsel = 1'b0, m_en = 1'b0, m_latch = 1'b0, m_flag = 1'b0;
  logic        m_eqq = 1'b0, m_oe = 1'b0;

  always #5 clk = ~clk;

  ocmp_unit dut_i (
    .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr), .cmp_wdata(cmp_wdata),
    .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .flag_clr(flag_clr),
    .dir_in(dir_in), .timer_a(timer_a), .timer_b(timer_b),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
  );

  function automatic logic act(input logic [3:0] md, input logic cur);
    if (md == 4'h8) return 1'b1;
    if (md == 4'h9) return 1'b0;
    if (md == 4'h2) return !cur;
    return cur;
  endfunction

  task automatic chk(input string req, input string what, input logic act_v, input logic exp_v);
    n_run++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act_v, exp_v, $time);
    end
  endtask

  // predict the coming edge, step, and compare at the negedge
  task automatic cyc(input string req);
    logic eq, hit;
    eq  = ((m_tsel ? timer_b : timer_a) == m_cmp);
    hit = eq && !m_eqq;
    if (ctl_wr && ctl_wdata == 6'd0) m_latch = 1'b0;
    else if (hit)                    m_latch = act(m_mode, m_latch);
    if (hit && m_mode != 4'd0) m_flag = 1'b1;
    else if (flag_clr)         m_flag = 1'b0;
    m_eqq = eq;
    m_oe  = !dir_in;
    if (cmp_wr) m_cmp = cmp_wdata;
    if (ctl_wr) begin
      m_mode = ctl_wdata[3:0]; m_tsel = ctl_wdata[4]; m_en = ctl_wdata[5];
    end
    @(posedge clk);
    @(negedge clk);
    cmp_wr = 1'b0; ctl_wr = 1'b0; flag_clr = 1'b0;
    chk(req, "pin_out", pin_out, m_oe & m_latch);
    chk(req, "pin_oe", pin_oe, m_oe);
    chk(req, "irq", irq, m_flag & m_en);
  endtask

  task automatic wctl(input logic en, input logic ts, input logic [3:0] md);
    ctl_wr = 1'b1; ctl_wdata = {en, ts, md};
  endtask

  task automatic wcmp(input logic [15:0] v);
    cmp_wr = 1'b1; cmp_wdata = v;
  endtask

  initial begin
    #200000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    #12;
    // R1 reset state
    chk("R1", "pin_out", pin_out, 1'b0);
    chk("R1", "pin_oe", pin_oe, 1'b0);
    chk("R1", "irq", irq, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    cyc("R1");
    // R12 enable pin
    dir_in = 1'b0; timer_a = 16'd5; timer_b = 16'd5;
    wcmp(16'd100); wctl(1'b1, 1'b0, 4'h8); cyc("R12");
    // R3 set on match of timer_a
    timer_a = 16'd100; cyc("R3");
    chk("R3", "pin_out direct", pin_out, 1'b1);
    // R8 hold: no retrigger; R9 clear flag while held
    flag_clr = 1'b1; cyc("R9");
    chk("R9", "irq after clear", irq, 1'b0);
    cyc("R8"); cyc("R8");
    chk("R8", "irq held timer", irq, 1'b0);
    // R4 clear mode
    timer_a = 16'd7; wctl(1'b1, 1'b0, 4'h9); cyc("R4");
    timer_a = 16'd100; cyc("R4");
    chk("R4", "pin_out direct", pin_out, 1'b0);
    // R5 toggle, held timer toggles once (R8)
    timer_a = 16'd1; wctl(1'b1, 1'b0, 4'h2); cyc("R5");
    timer_a = 16'd100; cyc("R5");
    chk("R5", "pin_out toggled", pin_out, 1'b1);
    cyc("R8"); cyc("R8");
    chk("R8", "no second toggle", pin_out, 1'b1);
    // R2 select timer_b; timer_a equal must be ignored
    timer_a = 16'd3; timer_b = 16'd9; wctl(1'b1, 1'b1, 4'h2); flag_clr = 1'b1; cyc("R2");
    timer_a = 16'd100; cyc("R2");
    chk("R2", "unselected timer ignored", pin_out, 1'b1);
    timer_b = 16'd100; cyc("R2");
    chk("R2", "timer_b toggles", pin_out, 1'b0);
    // R6 software interrupt mode
    timer_b = 16'd0; wctl(1'b1, 1'b1, 4'hA); flag_clr = 1'b1; cyc("R6");
    timer_b = 16'd100; cyc("R6");
    chk("R6", "irq set", irq, 1'b1);
    chk("R6", "latch kept", pin_out, 1'b0);
    // R7 other nonzero code, and mode zero
    timer_b = 16'd0; wctl(1'b1, 1'b1, 4'h5); flag_clr = 1'b1; cyc("R7");
    timer_b = 16'd100; cyc("R7");
    chk("R7", "irq other code", irq, 1'b1);
    // R10 disable irq with flag still set
    wctl(1'b0, 1'b1, 4'h5); cyc("R10");
    chk("R10", "irq masked", irq, 1'b0);
    // R9 set beats clear in same cycle
    timer_b = 16'd0; wctl(1'b1, 1'b1, 4'h8); cyc("R9");
    timer_b = 16'd100; flag_clr = 1'b1; cyc("R9");
    chk("R9", "set wins", irq, 1'b1);
    // R11 zero control overrides a match
    timer_b = 16'd0; cyc("R11");
    timer_b = 16'd100; ctl_wr = 1'b1; ctl_wdata = 6'd0; cyc("R11");
    chk("R11", "forced low", pin_out, 1'b0);
    // R12 direction input disables pin
    wctl(1'b1, 1'b0, 4'h8); timer_a = 16'd0; cyc("R12");
    timer_a = 16'd100; dir_in = 1'b1; cyc("R12");
    chk("R12", "pin gated", pin_out, 1'b0);
    dir_in = 1'b0; cyc("R12");
    chk("R12", "pin restored", pin_out, 1'b1);
    // R7 mode zero: no flag
    flag_clr = 1'b1; ctl_wr = 1'b1; ctl_wdata = 6'b100000; timer_a = 16'd0; cyc("R7");
    timer_a = 16'd100; cyc("R7");
    chk("R7", "mode zero no flag", irq, 1'b0);
    // constrained random
    for (int i = 0; i < 3000; i++) begin
      logic [3:0] pick;
      pick = 4'($urandom_range(0, 15));
      case ($urandom_range(0, 3))
        0: timer_a = m_cmp;
        1: timer_a = m_cmp + 16'd1;
        2: ;
        default: timer_a = 16'($urandom());
      endcase
      case ($urandom_range(0, 3))
        0: timer_b = m_cmp;
        1: timer_b = m_cmp ^ 16'h0100;
        2: ;
        default: timer_b = 16'($urandom());
      endcase
      if ($urandom_range(0, 15) == 0) wcmp(16'($urandom_range(0, 3)) + m_cmp);
      if ($urandom_range(0, 9) == 0) begin
        case (pick[1:0])
          0: wctl(1'($urandom()), 1'($urandom()), 4'h2);
          1: wctl(1'($urandom()), 1'($urandom()), 4'h8);
          2: wctl(1'($urandom()), 1'($urandom()), 4'h9);
          default: begin ctl_wr = 1'b1; ctl_wdata = 6'($urandom()); end
        endcase
      end
      flag_clr = ($urandom_range(0, 7) == 0);
      dir_in   = ($urandom_range(0, 15) == 0);
      cyc("R2");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule